// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through Read

This block moves data words from a write clock domain to an unrelated read clock domain through a power-of-two memory of `DEPTH` entries. Pointers cross the boundary as Gray code through two-stage synchronizers. Each status flag is computed in the domain whose port it guards. Read-side flags live in the read domain. Write-side, half-full and almost-full flags live in the write domain.

A mode input is captured during master reset. In requested-read mode, every word, the first one included, is taken by asserting the read enable on a read-clock edge. The data register then changes after that edge. In fall-through mode, an output register prefetches the oldest word with no request, and the read enable consumes the word on display. The output register adds one word of storage, so capacity is `DEPTH+1` in this mode, and every fill threshold moves up by one word. The same two flag pins change their meaning with the mode.

The almost-empty and almost-full thresholds come from two offset inputs, which are also captured at reset. An offset value of zero selects the parameter default for that offset.

Top module: `dcf_fifo`

## Requirements
- R1: `fwft_i` is captured only while `rst_ni` is low and on the first write/read clock edge after release (0 = requested-read, 1 = fall-through). Changing it afterwards has no effect on flag polarity or read behaviour.
- R2: In both modes, words leave in the order they were accepted, and `rdata_o` holds its value while no read takes place.
- R3: In requested-read mode, `rd_flag_o` is 0 while no word is stored and 1 once at least one word is stored. `rdata_o` changes only after a read-clock edge with `rd_en_i`=1.
- R4: In requested-read mode, `wr_flag_o` goes 0 when `DEPTH` words are stored. Writes attempted while full are dropped.
- R5: In fall-through mode, the first word written into an empty FIFO appears on `rdata_o` with `rd_flag_o`=0 within 2 to 4 read-clock edges after the write edge, with no read enable. `rd_flag_o`=1 means no word is on display, and a shown word stays stable until it is read.
- R6: In fall-through mode, `wr_flag_o` goes 1 when `DEPTH+1` words are stored, and writes are then dropped. The first read from full returns it to 0.
- R7: `almost_empty_no` is 0 while the stored word count is at most n (requested-read) or at most n+1 (fall-through). Otherwise it is 1.
- R8: `half_full_no` is 0 while the count is at least `DEPTH/2+1` (requested-read) or at least `DEPTH/2+2` (fall-through). Otherwise it is 1.
- R9: `almost_full_no` is 0 while the count is at least `DEPTH-m` (requested-read) or at least `DEPTH+1-m` (fall-through). Otherwise it is 1.
- R10: A read enable while nothing is stored changes neither `rdata_o` nor any flag, and it causes no later word loss or duplication.
- R11: n and m are captured from `ae_off_i`/`af_off_i` with the same timing as R1. A captured value of 0 selects `AE_DEF`/`AF_DEF` instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous active-low master reset |
| fwft_i | input | 1 | Mode select captured at reset: 1 = fall-through |
| ae_off_i | input | OW | Almost-empty offset n, 0 = default |
| af_off_i | input | OW | Almost-full offset m, 0 = default |
| wr_en_i | input | 1 | Write request, active high |
| wdata_i | input | DW | Write data |
| wr_flag_o | output | 1 | Requested-read: 0 = full. Fall-through: 1 = full |
| half_full_no | output | 1 | 0 = more than half full (mode-shifted) |
| almost_full_no | output | 1 | 0 = almost full |
| rd_en_i | input | 1 | Read request, active high |
| rdata_o | output | DW | Read data register |
| rd_flag_o | output | 1 | Requested-read: 0 = empty. Fall-through: 0 = data valid |
| almost_empty_no | output | 1 | 0 = almost empty |

## Verification
The embedded assertions check the following on every cycle in each domain:
- the pointer distance never exceeds `DEPTH`;
- full implies almost-full and half-full;
- an empty memory implies almost-empty;
- a fall-through word on display stays put until it is consumed.

Only the bench scenarios can show the rest:
- the per-level flag thresholds in both modes, including the one-word shift;
- word ordering under random traffic with unrelated clocks;
- the prefetch latency window of the first word;
- that reads on empty and writes on full leave no trace;
- that the mode and offsets ignore changes after reset.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic {
    MODE_REQ  = 1'b0,
    MODE_FWFT = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int N = 1 << AW;

  logic [DW-1:0] mem_q [N];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl import dcf_pkg::*; #(
  parameter int DEPTH  = 16,
  parameter int AF_DEF = 3,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic [PW-1:0] af_off_i,
  input  logic          wr_en_i,
  input  logic [PW-1:0] rgray_i,
  output logic [PW-1:0] wgray_o,
  output logic [AW-1:0] waddr_o,
  output logic          we_o,
  output logic          wr_flag_o,
  output logic          half_full_no,
  output logic          almost_full_no
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);
  localparam logic [PW-1:0] AFD_P   = PW'(AF_DEF);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    for (int i = 0; i < PW; i++) b[i] = ^(g >> i);
    return b;
  endfunction

  logic          in_rst_q;
  rd_mode_e      mode_q;
  logic [PW-1:0] m_q;
  logic [PW-1:0] wbin_q, wbin_n, rbin, cnt;
  logic          full;

  // config capture window: reset plus first edge after release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_rst_q <= 1'b1;
    else         in_rst_q <= 1'b0;
  end

  always_ff @(posedge clk_i) begin
    if (in_rst_q) begin
      mode_q <= rd_mode_e'(mode_i);
      m_q    <= (af_off_i == '0) ? AFD_P : af_off_i;
    end
  end

  assign rbin   = g2b(rgray_i);
  assign cnt    = wbin_q - rbin;
  assign full   = (cnt == DEPTH_P);
  assign we_o   = wr_en_i && !full;
  assign wbin_n = wbin_q + PW'(we_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_o <= '0;
    end else begin
      wbin_q  <= wbin_n;
      wgray_o <= wbin_n ^ (wbin_n >> 1);
    end
  end

  assign waddr_o        = wbin_q[AW-1:0];
  assign wr_flag_o      = (mode_q == MODE_FWFT) ? full : !full;
  assign half_full_no   = !(cnt > HALF_P);
  assign almost_full_no = !(cnt >= (DEPTH_P - m_q));

  AST_WCNT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= DEPTH_P); // R4
  AST_FULL_IMPLIES_AF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full |-> (!almost_full_no && !half_full_no)); // R9
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl import dcf_pkg::*; #(
  parameter int DW     = 8,
  parameter int DEPTH  = 16,
  parameter int AE_DEF = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic [PW-1:0] ae_off_i,
  input  logic          rd_en_i,
  input  logic [PW-1:0] wgray_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic [PW-1:0] rgray_o,
  output logic [DW-1:0] rdata_o,
  output logic          rd_flag_o,
  output logic          almost_empty_no
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] AED_P   = PW'(AE_DEF);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    for (int i = 0; i < PW; i++) b[i] = ^(g >> i);
    return b;
  endfunction

  logic          in_rst_q;
  rd_mode_e      mode_q;
  logic [PW-1:0] n_q;
  logic [PW-1:0] rbin_q, rbin_n, wbin, cnt;
  logic          mem_empty, pop, ov_q, ov_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_rst_q <= 1'b1;
    else         in_rst_q <= 1'b0;
  end

  always_ff @(posedge clk_i) begin
    if (in_rst_q) begin
      mode_q <= rd_mode_e'(mode_i);
      n_q    <= (ae_off_i == '0) ? AED_P : ae_off_i;
    end
  end

  assign wbin      = g2b(wgray_i);
  assign cnt       = wbin - rbin_q;
  assign mem_empty = (cnt == '0);

  // fall-through refills the output register whenever it is free or being consumed
  always_comb begin
    if (mode_q == MODE_FWFT) begin
      pop  = !mem_empty && (!ov_q || rd_en_i);
      ov_n = pop ? 1'b1 : (rd_en_i ? 1'b0 : ov_q);
    end else begin
      pop  = rd_en_i && !mem_empty;
      ov_n = 1'b0;
    end
  end

  assign rbin_n = rbin_q + PW'(pop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_o <= '0;
      ov_q    <= 1'b0;
      rdata_o <= '0;
    end else begin
      rbin_q  <= rbin_n;
      rgray_o <= rbin_n ^ (rbin_n >> 1);
      ov_q    <= ov_n;
      if (pop) rdata_o <= mem_rdata_i;
    end
  end

  assign raddr_o         = rbin_q[AW-1:0];
  assign rd_flag_o       = (mode_q == MODE_FWFT) ? !ov_q : !mem_empty;
  assign almost_empty_no = (cnt > n_q);

  AST_RCNT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= DEPTH_P); // R10
  AST_EMPTY_IMPLIES_AE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_empty |-> !almost_empty_no); // R7
  AST_FWFT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_FWFT && ov_q && !rd_en_i) |=> (ov_q && $stable(rdata_o))); // R5
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo import dcf_pkg::*; #(
  parameter int DW     = 8,
  parameter int DEPTH  = 16,
  parameter int AE_DEF = 2,
  parameter int AF_DEF = 3,
  localparam int AW = $clog2(DEPTH),
  localparam int OW = AW + 1
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          fwft_i,
  input  logic [OW-1:0] ae_off_i,
  input  logic [OW-1:0] af_off_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  output logic          wr_flag_o,
  output logic          half_full_no,
  output logic          almost_full_no,
  input  logic          rd_en_i,
  output logic [DW-1:0] rdata_o,
  output logic          rd_flag_o,
  output logic          almost_empty_no
);
  logic [OW-1:0] wgray, rgray, wgray_rs, rgray_ws;
  logic [AW-1:0] waddr, raddr;
  logic          we;
  logic [DW-1:0] mem_rdata;

  dcf_mem #(.DW(DW), .AW(AW)) u_mem (
    .wclk_i  (wclk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata_i),
    .raddr_i (raddr),
    .rdata_o (mem_rdata)
  );

  dcf_sync #(.W(OW), .STAGES(2)) u_sync_w2r (
    .clk_i  (rclk_i),
    .rst_ni (rst_ni),
    .d_i    (wgray),
    .q_o    (wgray_rs)
  );

  dcf_sync #(.W(OW), .STAGES(2)) u_sync_r2w (
    .clk_i  (wclk_i),
    .rst_ni (rst_ni),
    .d_i    (rgray),
    .q_o    (rgray_ws)
  );

  dcf_wr_ctl #(.DEPTH(DEPTH), .AF_DEF(AF_DEF)) u_wr (
    .clk_i          (wclk_i),
    .rst_ni         (rst_ni),
    .mode_i         (fwft_i),
    .af_off_i       (af_off_i),
    .wr_en_i        (wr_en_i),
    .rgray_i        (rgray_ws),
    .wgray_o        (wgray),
    .waddr_o        (waddr),
    .we_o           (we),
    .wr_flag_o      (wr_flag_o),
    .half_full_no   (half_full_no),
    .almost_full_no (almost_full_no)
  );

  dcf_rd_ctl #(.DW(DW), .DEPTH(DEPTH), .AE_DEF(AE_DEF)) u_rd (
    .clk_i           (rclk_i),
    .rst_ni          (rst_ni),
    .mode_i          (fwft_i),
    .ae_off_i        (ae_off_i),
    .rd_en_i         (rd_en_i),
    .wgray_i         (wgray_rs),
    .mem_rdata_i     (mem_rdata),
    .raddr_o         (raddr),
    .rgray_o         (rgray),
    .rdata_o         (rdata_o),
    .rd_flag_o       (rd_flag_o),
    .almost_empty_no (almost_empty_no)
  );
endmodule

// File: tb/dcf_fifo_tb.sv
`timescale 1ns/1ps
module dcf_fifo_tb;
  localparam int DW = 8, D = 16, AE_DEF = 2, AF_DEF = 3;
  localparam int OW = $clog2(D) + 1;

  logic wclk = 0, rclk = 0, rst_n = 0, fwft = 0, wr_en = 0, rd_en = 0;
  logic [OW-1:0] ae_off = 0, af_off = 0;
  logic [DW-1:0] wdata = 0, rdata;
  logic wr_flag, hf_n, af_n, rd_flag, ae_n;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit fw;
  int n_eff, m_eff, cap;
  bit use_def;
  logic [DW-1:0] q[$];

  always #2   wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  dcf_fifo #(.DW(DW), .DEPTH(D), .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)) u_dut (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n), .fwft_i(fwft),
    .ae_off_i(ae_off), .af_off_i(af_off), .wr_en_i(wr_en), .wdata_i(wdata),
    .wr_flag_o(wr_flag), .half_full_no(hf_n), .almost_full_no(af_n),
    .rd_en_i(rd_en), .rdata_o(rdata), .rd_flag_o(rd_flag), .almost_empty_no(ae_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic settle();
    repeat (6) @(posedge rclk);
    repeat (6) @(posedge wclk);
    @(negedge rclk);
  endtask

  // expected flags for k stored words, computed from the requirements
  task automatic check_flags(input int k);
    logic e_rd, e_wr, e_ae, e_hf, e_af;
    if (!fw) begin
      e_rd = (k > 0);              // R3
      e_wr = !(k == D);            // R4
      e_ae = !(k <= n_eff);
      e_hf = !(k >= D/2 + 1);
      e_af = !(k >= D - m_eff);
    end else begin
      e_rd = !(k > 0);             // R5
      e_wr = (k == D + 1);         // R6
      e_ae = !(k <= n_eff + 1);
      e_hf = !(k >= D/2 + 2);
      e_af = !(k >= D + 1 - m_eff);
    end
    check(fw ? "R5 rd_flag" : "R3 rd_flag", 32'(rd_flag), 32'(e_rd));
    check(fw ? "R6 wr_flag" : "R4 wr_flag", 32'(wr_flag), 32'(e_wr));
    check(use_def ? "R7 R11 almost_empty" : "R7 almost_empty", 32'(ae_n), 32'(e_ae));
    check("R8 half_full", 32'(hf_n), 32'(e_hf));
    check(use_def ? "R9 R11 almost_full" : "R9 almost_full", 32'(af_n), 32'(e_af));
  endtask

  task automatic do_reset(input bit mode, input int n_in, input int m_in);
    rst_n = 0; wr_en = 0; rd_en = 0;
    fwft = mode; ae_off = OW'(n_in); af_off = OW'(m_in);
    fw = mode; cap = mode ? D + 1 : D;
    use_def = (n_in == 0);
    n_eff = (n_in == 0) ? AE_DEF : n_in;
    m_eff = (m_in == 0) ? AF_DEF : m_in;
    q.delete();
    repeat (4) @(posedge wclk);
    repeat (4) @(posedge rclk);
    @(negedge wclk) rst_n = 1;
    repeat (3) @(posedge rclk);
    repeat (3) @(posedge wclk);
    // late changes must be ignored (R1, R11)
    fwft = ~mode; ae_off = OW'(D - 1); af_off = OW'(1);
    settle();
    check("R1 mode kept rd_flag", 32'(rd_flag), mode ? 32'd1 : 32'd0);
    check("R1 mode kept wr_flag", 32'(wr_flag), mode ? 32'd0 : 32'd1);
    check("R2 reset rdata", 32'(rdata), 32'd0);
    check_flags(0);
  endtask

  task automatic write_one(input logic [DW-1:0] d);
    @(negedge wclk);
    if (q.size() < cap) q.push_back(d);
    wr_en = 1; wdata = d;
    @(negedge wclk) wr_en = 0;
  endtask

  task automatic read_one();
    logic [DW-1:0] e;
    e = q.pop_front();
    @(negedge rclk);
    if (fw) check("R5 R2 shown word", 32'(rdata), 32'(e));
    rd_en = 1;
    @(negedge rclk) rd_en = 0;
    if (!fw) check("R3 R2 read word", 32'(rdata), 32'(e));
  endtask

  task automatic empty_read_test();
    logic [DW-1:0] prev;
    int edges;
    prev = rdata;
    @(negedge rclk) rd_en = 1;
    @(negedge rclk) rd_en = 0;
    settle();
    check("R10 rdata on empty read", 32'(rdata), 32'(prev));
    check("R10 flag on empty read", 32'(rd_flag), fw ? 32'd1 : 32'd0);
    if (fw) begin
      @(negedge wclk) begin wr_en = 1; wdata = 8'h5A; end
      @(negedge wclk) wr_en = 0;
      edges = 0;
      while (rd_flag !== 1'b0 && edges < 10) begin
        @(posedge rclk); edges++; #1;
      end
      check("R5 fall-through latency ok", 32'(edges >= 2 && edges <= 4), 32'd1);
      check("R5 fall-through word", 32'(rdata), 32'h5A);
      q.push_back(8'h5A);
      read_one();
    end else begin
      write_one(8'h5A);
      settle();
      read_one();
    end
    settle();
    check_flags(0);
  endtask

  task automatic random_phase();
    fork
      begin
        for (int i = 0; i < 1200; i++) begin
          @(negedge wclk);
          wr_en = 0;
          if ($urandom % 100 < 55) begin
            logic [DW-1:0] d;
            logic full_now;
            d = DW'($urandom);
            full_now = fw ? wr_flag : !wr_flag;
            wr_en = 1; wdata = d;
            if (!full_now) q.push_back(d);
          end
        end
        @(negedge wclk) wr_en = 0;
      end
      begin
        bit pend = 0;
        logic [DW-1:0] e = 0;
        for (int i = 0; i < 900; i++) begin
          @(negedge rclk);
          if (pend) check("R2 random order", 32'(rdata), 32'(e));
          pend = 0;
          rd_en = ($urandom % 100 < 50);
          if (fw) begin
            if (rd_en && rd_flag == 1'b0) begin
              e = q.pop_front();
              check("R2 random order", 32'(rdata), 32'(e));
            end
          end else if (rd_en && rd_flag == 1'b1) begin
            e = q.pop_front();
            pend = 1;
          end
        end
        @(negedge rclk);
        if (pend) check("R2 random order", 32'(rdata), 32'(e));
        rd_en = 0;
      end
    join
    settle();
    check_flags(q.size());
    while (q.size() > 0) begin
      read_one();
      settle();
    end
    check_flags(0);
  endtask

  task automatic run_mode(input bit mode, input int n_in, input int m_in);
    do_reset(mode, n_in, m_in);
    for (int i = 0; i < cap + 2; i++) begin
      write_one(DW'(8'h10 + i));
      settle();
      check_flags(q.size());
    end
    while (q.size() > 0) begin
      read_one();
      settle();
      check_flags(q.size());
    end
    empty_read_test();
    random_phase();
  endtask

  initial begin
    repeat (190000) @(posedge wclk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd7));
    run_mode(1'b0, 0, 0);
    run_mode(1'b1, 3, 2);
    run_mode(1'b0, 5, 4);
    run_mode(1'b1, 0, 0);
    summary();
  end
endmodule